// File: doc/BRIEF.md
# Three-Format Instruction Decode and Execute Unit

This unit accepts one 32-bit instruction word per clock together with the two source register values already read for it. It splits the word into fields, decodes a fixed opcode and function-code set across three formats (register, immediate, jump), chooses the second ALU operand (register value or extended immediate), and computes the result. The result, the destination register index, a register-write enable, memory read/write strobes, the store data and an illegal-instruction flag are all registered, so they appear one clock after the instruction is presented.

The source register indices are brought out combinationally from the instruction word, so that a register file outside the block can supply the two operand values in the same cycle. Loads and stores do not touch memory here. The unit only produces the byte address (base register plus sign-extended offset) and the strobes. Branch and jump formats are not executed and are reported as illegal.

Top module: `insn_exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every registered output (`result`, `store_data`, `dest_idx`, `reg_we`, `mem_rd`, `mem_wr`, `illegal`) is zero after that edge.
- R2: With opcode bits [31:26] = 000000, function bits [5:0] = 100000 gives rs+rt and 100010 gives rs-rt. Both wrap modulo 2^32, write to rd (bits [15:11]) and appear one clock after the instruction.
- R3: Set-less-than (register form funct 101010, immediate form opcode 001010 with a sign-extended immediate) returns 1 when the first operand is smaller as a two's-complement number, and 0 otherwise.
- R4: Immediate add (opcode 001000) adds the sign-extended 16-bit immediate (bits [15:0]) to rs and writes to rt (bits [20:16]).
- R5: Immediate AND (opcode 001100) and immediate OR (opcode 001101) use the zero-extended immediate and write to rt.
- R6: Load-upper-immediate (opcode 001111) returns the immediate in bits 31..16 with bits 15..0 cleared, and writes to rt.
- R7: Word load (opcode 100011) returns the address rs + sign-extended offset, raises `mem_rd`, and writes to rt.
- R8: Word store (opcode 101011) returns the address rs + sign-extended offset, raises `mem_wr`, puts the rt value on `store_data`, and leaves `reg_we` low and `dest_idx` at 0. `store_data` is 0 for every other instruction.
- R9: A destination index of 0 forces `reg_we` low, and `dest_idx` is reported as 0. The memory strobes of that instruction are unaffected.
- R10: Any other opcode, or opcode 000000 with any other function code, raises `illegal` and drives `result`, `dest_idx`, `reg_we`, `mem_rd`, `mem_wr` and `store_data` to 0.
- R11: `rs_sel` equals instruction bits [25:21] and `rt_sel` equals bits [20:16] in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word to decode this cycle |
| src_a | input | 32 | Value of the register named by `rs_sel` |
| src_b | input | 32 | Value of the register named by `rt_sel` |
| rs_sel | output | 5 | First source register index (combinational) |
| rt_sel | output | 5 | Second source register index (combinational) |
| result | output | 32 | ALU result or memory address (registered) |
| store_data | output | 32 | Data to write for a store (registered) |
| dest_idx | output | 5 | Register to be written (registered) |
| reg_we | output | 1 | Register write enable (registered) |
| mem_rd | output | 1 | Memory read strobe (registered) |
| mem_wr | output | 1 | Memory write strobe (registered) |
| illegal | output | 1 | Unrecognised encoding (registered) |

## Verification
Two effects can meet in one instruction: a load whose target field is register 0 must still raise the memory read strobe and produce its address, while the zero-target suppression drops the register write. The bench provokes this with a load that names register 0 as target and a register add that names rd = 0. It judges the first by `mem_rd` high with the correct address, `reg_we` low and `dest_idx` 0, and the second by a correct sum with no write. A similar overlap of set-less-than with sign extension is provoked with a negative base and the most negative immediate.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int INSN_W  = 32;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 5;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'b001111;
  localparam logic [OPC_W-1:0] OPC_LOADW = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STOREW= 6'b101011;

  localparam logic [FN_W-1:0]  FN_ADD    = 6'b100000;
  localparam logic [FN_W-1:0]  FN_SUB    = 6'b100010;
  localparam logic [FN_W-1:0]  FN_SLT    = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_LUI
  } alu_op_e;

  typedef enum logic {
    EXT_SIGN, EXT_ZERO
  } ext_mode_e;

  typedef struct packed {
    alu_op_e   alu_op;
    logic      use_imm;
    ext_mode_e ext;
    logic      dest_is_rd;
    logic      writes_reg;
    logic      mem_rd;
    logic      mem_wr;
    logic      illegal;
  } ctrl_t;
endpackage

// File: rtl/insn_decode.sv
module insn_decode
  import exec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic [IDX_W-1:0]  rs_f,
  output logic [IDX_W-1:0]  rt_f,
  output logic [IDX_W-1:0]  rd_f,
  output logic [IMM_W-1:0]  imm_f,
  output ctrl_t             ctrl
);
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - IDX_W;
  localparam int RT_LSB  = RS_LSB - IDX_W;
  localparam int RD_LSB  = RT_LSB - IDX_W;

  logic [OPC_W-1:0] opc_f;
  logic [FN_W-1:0]  fn_f;

  assign opc_f = insn[INSN_W-1:OPC_LSB];
  assign rs_f  = insn[RS_LSB +: IDX_W];
  assign rt_f  = insn[RT_LSB +: IDX_W];
  assign rd_f  = insn[RD_LSB +: IDX_W];
  assign imm_f = insn[IMM_W-1:0];
  assign fn_f  = insn[FN_W-1:0];

  always_comb begin
    ctrl            = '0;
    ctrl.alu_op     = ALU_ADD;
    ctrl.ext        = EXT_SIGN;
    ctrl.writes_reg = 1'b1;
    unique case (opc_f)
      OPC_REG: begin
        ctrl.dest_is_rd = 1'b1;
        unique case (fn_f)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: begin
            ctrl.illegal    = 1'b1;
            ctrl.writes_reg = 1'b0;
          end
        endcase
      end
      OPC_ADDI: begin
        ctrl.use_imm = 1'b1;
      end
      OPC_SLTI: begin
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_SLT;
      end
      OPC_ANDI: begin
        ctrl.use_imm = 1'b1;
        ctrl.ext     = EXT_ZERO;
        ctrl.alu_op  = ALU_AND;
      end
      OPC_ORI: begin
        ctrl.use_imm = 1'b1;
        ctrl.ext     = EXT_ZERO;
        ctrl.alu_op  = ALU_OR;
      end
      OPC_LUI: begin
        ctrl.use_imm = 1'b1;
        ctrl.ext     = EXT_ZERO;
        ctrl.alu_op  = ALU_LUI;
      end
      OPC_LOADW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OPC_STOREW: begin
        ctrl.use_imm    = 1'b1;
        ctrl.mem_wr     = 1'b1;
        ctrl.writes_reg = 1'b0;
      end
      default: begin
        ctrl.illegal    = 1'b1;
        ctrl.writes_reg = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/operand_sel.sv
module operand_sel
  import exec_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic [IMM_W-1:0] imm_f,
  input  ext_mode_e        ext,
  input  logic             use_imm,
  input  logic [WIDTH-1:0] reg_val,
  output logic [WIDTH-1:0] opnd
);
  localparam int PAD_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] imm_ext;

  always_comb begin
    if (ext == EXT_SIGN) imm_ext = {{PAD_W{imm_f[IMM_W-1]}}, imm_f};
    else                 imm_ext = {{PAD_W{1'b0}}, imm_f};
    opnd = use_imm ? imm_ext : reg_val;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import exec_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] y
);
  localparam int LOW_W = WIDTH - IMM_W;

  logic lt_signed;
  assign lt_signed = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(WIDTH-1){1'b0}}, lt_signed};
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_LUI: y = {b[IMM_W-1:0], {LOW_W{1'b0}}};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/insn_exec_unit.sv
module insn_exec_unit
  import exec_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] insn,
  input  logic [WIDTH-1:0]  src_a,
  input  logic [WIDTH-1:0]  src_b,
  output logic [IDX_W-1:0]  rs_sel,
  output logic [IDX_W-1:0]  rt_sel,
  output logic [WIDTH-1:0]  result,
  output logic [WIDTH-1:0]  store_data,
  output logic [IDX_W-1:0]  dest_idx,
  output logic              reg_we,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              illegal
);
  logic [IDX_W-1:0] rd_f;
  logic [IMM_W-1:0] imm_f;
  ctrl_t            ctrl;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] alu_y;
  logic [IDX_W-1:0] dest_raw;
  logic             we_nxt;

  insn_decode u_dec (
    .insn  (insn),
    .rs_f  (rs_sel),
    .rt_f  (rt_sel),
    .rd_f  (rd_f),
    .imm_f (imm_f),
    .ctrl  (ctrl)
  );

  operand_sel #(.WIDTH(WIDTH)) u_opsel (
    .imm_f   (imm_f),
    .ext     (ctrl.ext),
    .use_imm (ctrl.use_imm),
    .reg_val (src_b),
    .opnd    (opnd_b)
  );

  alu_core #(.WIDTH(WIDTH)) u_alu (
    .a  (src_a),
    .b  (opnd_b),
    .op (ctrl.alu_op),
    .y  (alu_y)
  );

  assign dest_raw = ctrl.dest_is_rd ? rd_f : rt_sel;
  assign we_nxt   = ctrl.writes_reg && (dest_raw != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      store_data <= '0;
      dest_idx   <= '0;
      reg_we     <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      result     <= ctrl.illegal ? '0 : alu_y;
      store_data <= ctrl.mem_wr ? src_b : '0;
      dest_idx   <= we_nxt ? dest_raw : '0;
      reg_we     <= we_nxt;
      mem_rd     <= ctrl.mem_rd;
      mem_wr     <= ctrl.mem_wr;
      illegal    <= ctrl.illegal;
    end
  end

  assert_lui_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (insn[INSN_W-1 -: OPC_W] == OPC_LUI) |=>
      (result == {$past(insn[IMM_W-1:0]), {(WIDTH-IMM_W){1'b0}}}));

  assert_slt_boolean_R3: assert property (@(posedge clk) disable iff (rst)
    ((insn[INSN_W-1 -: OPC_W] == OPC_SLTI) ||
     (insn[INSN_W-1 -: OPC_W] == OPC_REG && insn[FN_W-1:0] == FN_SLT)) |=>
      (result[WIDTH-1:1] == '0));

  assert_no_zero_write_R9: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (dest_idx != '0));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!reg_we && !mem_rd && !mem_wr && result == '0));

  assert_store_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (!reg_we && !mem_rd && store_data == $past(src_b)));

  assert_src_fields_R11: assert property (@(posedge clk) disable iff (rst)
    (rs_sel == insn[25:21]) && (rt_sel == insn[20:16]));
endmodule

// File: tb/test_insn_exec_unit.sv
`timescale 1ns/1ps
module test_insn_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [4:0]  rs_sel, rt_sel, dest_idx;
  logic [31:0] result, store_data;
  logic        reg_we, mem_rd, mem_wr, illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  insn_exec_unit i_insn_exec_unit (
    .clk(clk), .rst(rst), .insn(insn), .src_a(src_a), .src_b(src_b),
    .rs_sel(rs_sel), .rt_sel(rt_sel), .result(result),
    .store_data(store_data), .dest_idx(dest_idx), .reg_we(reg_we),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .illegal(illegal)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] s, input logic [4:0] t,
                                        input logic [4:0] d, input logic [5:0] f);
    return {6'b000000, s, t, d, 5'b00000, f};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] o, input logic [4:0] s,
                                        input logic [4:0] t, input logic [15:0] im);
    return {o, s, t, im};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [31:0] st;
    logic [4:0]  dst;
    logic [3:0]  flg;   // {reg_we, mem_rd, mem_wr, illegal}
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    // R2 add / sub / wrap
    '{enc_r(5'd1,5'd2,5'd3,6'b100000), 32'd5, 32'd7, 32'd12, 32'd0, 5'd3, 4'b1000, 8'd2},
    '{enc_r(5'd1,5'd2,5'd4,6'b100010), 32'd5, 32'd7, 32'hFFFFFFFE, 32'd0, 5'd4, 4'b1000, 8'd2},
    '{enc_r(5'd1,5'd2,5'd3,6'b100000), 32'h7FFFFFFF, 32'd1, 32'h80000000, 32'd0, 5'd3, 4'b1000, 8'd2},
    // R3 slt signed
    '{enc_r(5'd1,5'd2,5'd5,6'b101010), 32'hFFFFFFFF, 32'd1, 32'd1, 32'd0, 5'd5, 4'b1000, 8'd3},
    '{enc_r(5'd1,5'd2,5'd5,6'b101010), 32'd3, 32'hFFFFFFFE, 32'd0, 32'd0, 5'd5, 4'b1000, 8'd3},
    '{enc_r(5'd1,5'd2,5'd5,6'b101010), 32'd9, 32'd9, 32'd0, 32'd0, 5'd5, 4'b1000, 8'd3},
    // R4 addi
    '{enc_i(6'b001000,5'd1,5'd6,16'hFFFF), 32'd10, 32'h55, 32'd9, 32'd0, 5'd6, 4'b1000, 8'd4},
    '{enc_i(6'b001000,5'd1,5'd6,16'h7FFF), 32'd1, 32'h55, 32'h00008000, 32'd0, 5'd6, 4'b1000, 8'd4},
    // R3 slti
    '{enc_i(6'b001010,5'd1,5'd7,16'h8000), 32'd0, 32'h55, 32'd0, 32'd0, 5'd7, 4'b1000, 8'd3},
    '{enc_i(6'b001010,5'd1,5'd7,16'h8000), 32'hFFFF0000, 32'h55, 32'd1, 32'd0, 5'd7, 4'b1000, 8'd3},
    // R5 andi / ori
    '{enc_i(6'b001100,5'd1,5'd8,16'hF0F0), 32'hFFFFFFFF, 32'h55, 32'h0000F0F0, 32'd0, 5'd8, 4'b1000, 8'd5},
    '{enc_i(6'b001101,5'd1,5'd9,16'h8001), 32'h12340000, 32'h55, 32'h12348001, 32'd0, 5'd9, 4'b1000, 8'd5},
    // R6 lui
    '{enc_i(6'b001111,5'd1,5'd10,16'hABCD), 32'h00001111, 32'h55, 32'hABCD0000, 32'd0, 5'd10, 4'b1000, 8'd6},
    // R7 load
    '{enc_i(6'b100011,5'd1,5'd11,16'hFFFC), 32'h100, 32'h55, 32'h000000FC, 32'd0, 5'd11, 4'b1100, 8'd7},
    '{enc_i(6'b100011,5'd1,5'd11,16'h0020), 32'h1000, 32'h55, 32'h00001020, 32'd0, 5'd11, 4'b1100, 8'd7},
    // R8 store
    '{enc_i(6'b101011,5'd1,5'd12,16'h0008), 32'h200, 32'hDEADBEEF, 32'h00000208, 32'hDEADBEEF, 5'd0, 4'b0010, 8'd8},
    // R9 zero destination (register add, and load that still reads)
    '{enc_r(5'd1,5'd2,5'd0,6'b100000), 32'd1, 32'd2, 32'd3, 32'd0, 5'd0, 4'b0000, 8'd9},
    '{enc_i(6'b100011,5'd1,5'd0,16'h0004), 32'h40, 32'h55, 32'h00000044, 32'd0, 5'd0, 4'b0100, 8'd9},
    // R10 unsupported encodings
    '{enc_r(5'd1,5'd2,5'd3,6'b100100), 32'd5, 32'd7, 32'd0, 32'd0, 5'd0, 4'b0001, 8'd10},
    '{enc_i(6'b000010,5'd1,5'd2,16'h0019), 32'd5, 32'd7, 32'd0, 32'd0, 5'd0, 4'b0001, 8'd10},
    '{enc_i(6'b000100,5'd1,5'd2,16'h0003), 32'd5, 32'd7, 32'd0, 32'd0, 5'd0, 4'b0001, 8'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all_zero(input string tag);
    chk({tag, " result"}, result, 32'd0);
    chk({tag, " store_data"}, store_data, 32'd0);
    chk({tag, " dest_idx"}, {27'd0, dest_idx}, 32'd0);
    chk({tag, " flags"}, {28'd0, reg_we, mem_rd, mem_wr, illegal}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all_zero("R1 reset");
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      insn  = VEC[k].ins;
      src_a = VEC[k].a;
      src_b = VEC[k].b;
      #1;
      chk($sformatf("R11 rs_sel v%0d", k), {27'd0, rs_sel}, {27'd0, VEC[k].ins[25:21]});
      chk($sformatf("R11 rt_sel v%0d", k), {27'd0, rt_sel}, {27'd0, VEC[k].ins[20:16]});
      @(negedge clk);
      chk($sformatf("R%0d result v%0d", VEC[k].req, k), result, VEC[k].res);
      chk($sformatf("R%0d store_data v%0d", VEC[k].req, k), store_data, VEC[k].st);
      chk($sformatf("R%0d dest_idx v%0d", VEC[k].req, k), {27'd0, dest_idx}, {27'd0, VEC[k].dst});
      chk($sformatf("R%0d flags v%0d", VEC[k].req, k),
          {28'd0, reg_we, mem_rd, mem_wr, illegal}, {28'd0, VEC[k].flg});
    end

    // R1: reset taken mid-run clears outputs of a store in flight
    @(negedge clk);
    insn  = enc_i(6'b101011, 5'd1, 5'd12, 16'h0010);
    src_a = 32'h300;
    src_b = 32'hCAFEF00D;
    @(negedge clk);
    chk("R8 store before reset", {31'd0, mem_wr}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk_all_zero("R1 mid-run reset");
    rst = 1'b0;

    // R6: lui with all-ones immediate, back-to-back after reset release
    insn  = enc_i(6'b001111, 5'd3, 5'd13, 16'hFFFF);
    src_a = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R6 lui all ones", result, 32'hFFFF0000);
    chk("R6 lui dest", {27'd0, dest_idx}, 32'd13);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule